// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

A 32-bit arithmetic unit that computes one of several saturating operations in the same cycle its operands arrive, and records in a sticky flag whether any qualified operation clamped its result. The operations are a wrapping signed add that only reports overflow, signed saturating add and subtract, signed saturating doubling, unsigned saturating add and subtract, and clamping of a value to a selected bit width. The width clamp comes in signed and unsigned forms and works on the full word or on each 16-bit half independently.

The result path is purely combinational. The flag is a single register. A saturation event sets it at the clock edge of a cycle with the valid strobe high. Only the dedicated clear input or reset brings it back to zero. Software-visible accumulation of the flag across a sequence of operations is the intended use.

Top module: `sat_arith_unit`

## Requirements
- R1: Operation code 0 returns the wrapped 32-bit sum of A and B unchanged and counts as a saturation event when the add overflows as a signed value (A and B share a sign and the sum's sign differs from A's).
- R2: Code 1 (signed add) and code 2 (signed subtract A−B) return 0x7FFFFFFF on signed overflow if A is non-negative and 0x80000000 if A is negative, and count as a saturation event. Subtract overflow means A and B differ in sign and the difference's sign differs from A's.
- R3: Code 3 doubles A as a signed value. An A of at least 0x40000000 gives 0x7FFFFFFF and an A of at most 0xC0000000 (signed) gives 0x80000000, both as saturation events. Any other A gives A shifted left by one.
- R4: Code 4 (unsigned add) returns 0xFFFFFFFF on carry out and code 5 (unsigned subtract A−B) returns 0 when B exceeds A, both as saturation events. Otherwise each returns the plain sum or difference.
- R5: Code 6 clamps signed A to width s (width select 0..31). If A ≥ 2^s the result is 2^s−1. If A < −2^s the result is −2^s. Both cases are saturation events; any other A passes through unchanged.
- R6: Code 8 clamps A, read as signed, to the unsigned range 0..2^s−1. Negative A gives 0 and A above 2^s−1 gives 2^s−1, both as saturation events.
- R7: Code 7 (signed) and code 9 (unsigned) apply the R5 and R6 clamps to each sign-extended 16-bit half of A separately and place the low 16 bits of each lane result in the matching half. Either half clamping is a saturation event.
- R8: The sticky flag is set at a rising clock edge when valid is high and the selected operation has a saturation event. Otherwise it keeps its value, and a saturation event with valid low leaves it unchanged.
- R9: A high clear input drops the flag to 0 at the next rising edge unless the same edge sets it (set wins over clear).
- R10: An active-low asynchronous reset forces the flag to 0.
- R11: Operation codes 10 to 15 return 0 and are never saturation events.
- R12: The result depends only on the operation code, A, B and the width select in the same cycle, whatever the state of valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code (0..9 defined) |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| width_sel | input | 5 | Saturation bit width s for codes 6..9 |
| valid | input | 1 | Qualifies the operation for updating the flag |
| flag_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The only state is the sticky flag, so a wrong internal value shows on sat_flag one edge after the qualifying cycle. A flag that is wrongly set stays visible until a clear, and a missed set is masked by any later saturating operation. A faulty overflow or clamp decode can corrupt the result in the same cycle, the flag one edge later, or both, so the bench compares the result combinationally and the flag after every edge. Boundary operands such as 0x40000000, 0xC0000000, width 0 and width 31 are the places where an off-by-one in a comparison or a mask shift would first appear.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_ADD_REPORT = 4'd0,
    OP_S_ADD      = 4'd1,
    OP_S_SUB      = 4'd2,
    OP_S_DOUBLE   = 4'd3,
    OP_U_ADD      = 4'd4,
    OP_U_SUB      = 4'd5,
    OP_S_CLAMP    = 4'd6,
    OP_S_CLAMP_H  = 4'd7,
    OP_U_CLAMP    = 4'd8,
    OP_U_CLAMP_H  = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] dif,
  output logic         s_ovf_add,
  output logic         s_ovf_sub,
  output logic         u_carry,
  output logic         u_borrow,
  output logic [W-1:0] s_limit
);
  logic [W:0] wide_sum;

  always_comb begin
    wide_sum  = {1'b0, a} + {1'b0, b};
    sum       = wide_sum[W-1:0];
    dif       = a - b;
    u_carry   = wide_sum[W];
    u_borrow  = (a < b);
    s_ovf_add = (sum[W-1] ^ a[W-1]) & ~(a[W-1] ^ b[W-1]);
    s_ovf_sub = (dif[W-1] ^ a[W-1]) &  (a[W-1] ^ b[W-1]);
    // clamp value picked by the sign of A
    s_limit   = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  end
endmodule

// File: rtl/sat_double.sv
module sat_double #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         hit
);
  logic too_big;
  logic too_small;

  always_comb begin
    too_big   = ~a[W-1] & a[W-2];
    too_small =  a[W-1] & (~a[W-2] | (a[W-3:0] == '0));
    hit       = too_big | too_small;
    if (too_big)
      res = {1'b0, {(W-1){1'b1}}};
    else if (too_small)
      res = {1'b1, {(W-1){1'b0}}};
    else
      res = {a[W-2:0], 1'b0};
  end
endmodule

// File: rtl/sat_clamp_lane.sv
module sat_clamp_lane #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] sel,
  input  logic          uns,
  output logic [W-1:0]  res,
  output logic          hit
);
  logic [W-1:0] lim_mask;
  logic [W-1:0] excess;
  logic         s_high;
  logic         s_low;
  logic         u_neg;
  logic         u_high;

  always_comb begin
    // sel < W, so the shift never reaches the full word width
    lim_mask = ({{(W-1){1'b0}}, 1'b1} << sel) - {{(W-1){1'b0}}, 1'b1};
    excess   = W'($signed(val) >>> sel);
    s_high   = ~excess[W-1] & (|excess);
    s_low    =  excess[W-1] & ~(&excess);
    u_neg    = val[W-1];
    u_high   = ~val[W-1] & (val > lim_mask);
    res      = val;
    hit      = 1'b0;
    if (uns) begin
      if (u_neg) begin
        res = '0;
        hit = 1'b1;
      end else if (u_high) begin
        res = lim_mask;
        hit = 1'b1;
      end
    end else begin
      if (s_high) begin
        res = lim_mask;
        hit = 1'b1;
      end else if (s_low) begin
        res = ~lim_mask;
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr,
  output logic flag
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = flag;
    if (set_en)
      flag_nxt = 1'b1;
    else if (clr)
      flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else
      flag <= flag_nxt;
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SEL_W-1:0]  width_sel,
  input  logic              valid,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] result,
  output logic              sat_flag
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int N_HALF  = 2;

  logic [DATA_W-1:0] sum, dif, s_limit, dbl_res, word_res;
  logic              ovf_add, ovf_sub, carry, borrow, dbl_hit, word_hit;
  logic              uns_clamp;
  logic [DATA_W-1:0] half_res [N_HALF];
  logic              half_hit [N_HALF];
  logic [DATA_W-1:0] packed_half;
  logic              any_half_hit;
  logic              sat_event;

  sat_addsub #(.W(DATA_W)) u_addsub (
    .a(opa), .b(opb), .sum(sum), .dif(dif),
    .s_ovf_add(ovf_add), .s_ovf_sub(ovf_sub),
    .u_carry(carry), .u_borrow(borrow), .s_limit(s_limit)
  );

  sat_double #(.W(DATA_W)) u_double (
    .a(opa), .res(dbl_res), .hit(dbl_hit)
  );

  assign uns_clamp = (op_sel == OP_U_CLAMP) || (op_sel == OP_U_CLAMP_H);

  sat_clamp_lane #(.W(DATA_W), .SW(SEL_W)) u_word_lane (
    .val(opa), .sel(width_sel), .uns(uns_clamp),
    .res(word_res), .hit(word_hit)
  );

  for (genvar k = 0; k < N_HALF; k++) begin : g_half
    logic [DATA_W-1:0] ext;
    assign ext = {{(DATA_W-HALF_W){opa[k*HALF_W+HALF_W-1]}}, opa[k*HALF_W +: HALF_W]};
    sat_clamp_lane #(.W(DATA_W), .SW(SEL_W)) u_lane (
      .val(ext), .sel(width_sel), .uns(uns_clamp),
      .res(half_res[k]), .hit(half_hit[k])
    );
    assign packed_half[k*HALF_W +: HALF_W] = half_res[k][HALF_W-1:0];
  end

  assign any_half_hit = half_hit[0] | half_hit[1];

  always_comb begin
    result    = '0;
    sat_event = 1'b0;
    case (op_sel)
      OP_ADD_REPORT: begin result = sum;                             sat_event = ovf_add;      end
      OP_S_ADD:      begin result = ovf_add ? s_limit : sum;         sat_event = ovf_add;      end
      OP_S_SUB:      begin result = ovf_sub ? s_limit : dif;         sat_event = ovf_sub;      end
      OP_S_DOUBLE:   begin result = dbl_res;                         sat_event = dbl_hit;      end
      OP_U_ADD:      begin result = carry ? '1 : sum;                sat_event = carry;        end
      OP_U_SUB:      begin result = borrow ? '0 : dif;               sat_event = borrow;       end
      OP_S_CLAMP,
      OP_U_CLAMP:    begin result = word_res;                        sat_event = word_hit;     end
      OP_S_CLAMP_H,
      OP_U_CLAMP_H:  begin result = packed_half;                     sat_event = any_half_hit; end
      default:       begin result = '0;                              sat_event = 1'b0;         end
    endcase
  end

  sat_sticky u_sticky (
    .clk(clk), .rst_n(rst_n),
    .set_en(valid & sat_event), .clr(flag_clr),
    .flag(sat_flag)
  );
endmodule

// File: rtl/sat_arith_unit_chk.sv
module sat_arith_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op_sel,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic [4:0]  width_sel,
  input logic        valid,
  input logic        flag_clr,
  input logic [31:0] result,
  input logic        sat_flag
);
  logic signed [33:0] lim;
  logic signed [33:0] res_ext;
  assign lim     = 34'sd1 <<< width_sel;
  assign res_ext = $signed({{2{result[31]}}, result});

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag);                               // R8
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_flag && !valid) |=> !sat_flag);                                // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !valid) |=> !sat_flag);                                 // R9
  AST_SADD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd1 && opa[31] == opb[31]) |-> result[31] == opa[31]);   // R2
  AST_DOUBLE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd3) |-> result[31] == opa[31]);                         // R3
  AST_UADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd4) |-> result >= opa);                                 // R4
  AST_USUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd5) |-> result <= opa);                                 // R4
  AST_UADD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op_sel == 4'd4 && ({1'b0, opa} + {1'b0, opb}) > 33'h0FFFFFFFF) |=> sat_flag); // R8
  AST_SCLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd6) |-> (res_ext < lim) && (res_ext >= -lim));          // R5
  AST_UCLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd8) |-> ({2'b00, result} < lim));                       // R6
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 4'd10) |-> result == 32'd0);                              // R11
endmodule

bind sat_arith_unit sat_arith_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
  .width_sel(width_sel), .valid(valid), .flag_clr(flag_clr),
  .result(result), .sat_flag(sat_flag)
);

// File: tb/sat_arith_unit_tb_top.sv
module sat_arith_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic [31:0] opa, opb;
  logic [4:0]  width_sel;
  logic        valid, flag_clr;
  logic [31:0] result;
  logic        sat_flag;

  int errors = 0;
  int checks = 0;
  logic flag_model = 1'b0;

  sat_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
    .width_sel(width_sel), .valid(valid), .flag_clr(flag_clr),
    .result(result), .sat_flag(sat_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint s_clamp(input longint v, input int s, inout logic h);
    longint lim = longint'(1) << s;
    if (v >= lim) begin h = 1'b1; return lim - 1; end
    if (v < -lim) begin h = 1'b1; return -lim; end
    return v;
  endfunction

  function automatic longint u_clamp(input longint v, input int s, inout logic h);
    longint lim = longint'(1) << s;
    if (v < 0) begin h = 1'b1; return 0; end
    if (v > lim - 1) begin h = 1'b1; return lim - 1; end
    return v;
  endfunction

  function automatic longint sat32(input longint v, inout logic h);
    if (v > 64'sd2147483647) begin h = 1'b1; return 64'sd2147483647; end
    if (v < -64'sd2147483648) begin h = 1'b1; return -64'sd2147483648; end
    return v;
  endfunction

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] s);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint lo = longint'($signed(a[15:0]));
    longint hi = longint'($signed(a[31:16]));
    longint r, r2;
    logic h = 1'b0;
    logic [31:0] res = 32'd0;
    case (op)
      4'd0: begin res = a + b; r = sat32(sa + sb, h); end
      4'd1: begin r = sat32(sa + sb, h); res = r[31:0]; end
      4'd2: begin r = sat32(sa - sb, h); res = r[31:0]; end
      4'd3: begin
        if (sa >= 64'sd1073741824) begin h = 1'b1; res = 32'h7FFFFFFF; end
        else if (sa <= -64'sd1073741824) begin h = 1'b1; res = 32'h80000000; end
        else begin r = 2 * sa; res = r[31:0]; end
      end
      4'd4: begin r = longint'(a) + longint'(b);
        if (r > 64'sh0FFFFFFFF) begin h = 1'b1; res = 32'hFFFFFFFF; end else res = r[31:0]; end
      4'd5: begin
        if (a < b) begin h = 1'b1; res = 32'd0; end else res = a - b; end
      4'd6: begin r = s_clamp(sa, int'(s), h); res = r[31:0]; end
      4'd8: begin r = u_clamp(sa, int'(s), h); res = r[31:0]; end
      4'd7: begin r = s_clamp(lo, int'(s), h); r2 = s_clamp(hi, int'(s), h);
        res = {r2[15:0], r[15:0]}; end
      4'd9: begin r = u_clamp(lo, int'(s), h); r2 = u_clamp(hi, int'(s), h);
        res = {r2[15:0], r[15:0]}; end
      default: begin res = 32'd0; h = 1'b0; end
    endcase
    return {h, res};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd8: return "R6";
      4'd7, 4'd9: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at negedge, check result mid-low-phase, check flag after the edge
  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s, input logic v, input logic c,
                       input string rtag, input string ftag);
    logic [32:0] m;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; width_sel = s; valid = v; flag_clr = c;
    m = model(op, a, b, s);
    #1;
    check((rtag == "") ? tag_of(op) : rtag, result, m[31:0]);
    @(posedge clk);
    if (v && m[32]) flag_model = 1'b1;
    else if (c) flag_model = 1'b0;
    #1;
    check(ftag, {31'd0, sat_flag}, {31'd0, flag_model});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A7F11));
    rst_n = 1'b0; op_sel = 4'd0; opa = '0; opb = '0; width_sel = '0;
    valid = 1'b0; flag_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", {31'd0, sat_flag}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 wrapping add reports overflow
    apply(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b1, 1'b0, "", "R1");
    apply(4'd0, 32'h1, 32'h1, 5'd0, 1'b1, 1'b1, "", "R9");
    // R2
    apply(4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd2, 32'h80000000, 32'h1, 5'd0, 1'b1, 1'b1, "", "R9");
    apply(4'd1, 32'h5, 32'h6, 5'd0, 1'b1, 1'b1, "", "R9");
    // R3 doubling boundaries
    apply(4'd3, 32'h3FFFFFFF, 32'h0, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd3, 32'h40000000, 32'h0, 5'd0, 1'b0, 1'b0, "", "R8");
    apply(4'd3, 32'hC0000001, 32'h0, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd3, 32'hC0000000, 32'h0, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b1, "", "R9");
    // R4
    apply(4'd4, 32'hFFFFFFFF, 32'h1, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd5, 32'h0, 32'h1, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd5, 32'h10, 32'h10, 5'd0, 1'b1, 1'b1, "", "R9");
    // R5 / R6 width ends
    apply(4'd6, 32'h1, 32'h0, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd6, 32'h80000000, 32'h0, 5'd31, 1'b1, 1'b1, "", "R9");
    apply(4'd6, 32'd200, 32'h0, 5'd7, 1'b1, 1'b0, "", "R8");
    apply(4'd6, 32'hFFFFFF80, 32'h0, 5'd7, 1'b1, 1'b1, "", "R9");
    apply(4'd8, 32'h5, 32'h0, 5'd0, 1'b1, 1'b0, "", "R8");
    apply(4'd8, 32'h80000000, 32'h0, 5'd31, 1'b1, 1'b1, "", "R8");
    apply(4'd8, 32'h7FFFFFFF, 32'h0, 5'd31, 1'b1, 1'b1, "", "R9");
    // R7 halves
    apply(4'd7, 32'h7FFF8000, 32'h0, 5'd8, 1'b1, 1'b1, "", "R8");
    apply(4'd7, 32'h00050005, 32'h0, 5'd20, 1'b1, 1'b1, "", "R9");
    apply(4'd9, 32'hFFFF0123, 32'h0, 5'd4, 1'b1, 1'b1, "", "R8");
    apply(4'd9, 32'h00030002, 32'h0, 5'd16, 1'b1, 1'b1, "", "R9");
    // R11 undefined codes, R12 result without valid
    apply(4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 1'b1, 1'b1, "", "R11");
    apply(4'd15, 32'h80000000, 32'h1, 5'd0, 1'b1, 1'b0, "", "R11");
    apply(4'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b0, 1'b0, "R12", "R8");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      logic [3:0]  rop;
      ra  = $urandom();
      rb  = $urandom();
      rop = 4'($urandom_range(0, 15));
      if (($urandom() & 3) == 0) ra = {ra[31], {31{~ra[31]}}};
      apply(rop, ra, rb, 5'($urandom_range(0, 31)), 1'($urandom()),
            (($urandom() & 7) == 0), "", "R8");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule